// File: doc/BRIEF.md
# Edge Phase Comparator with Lock Mask

This block compares the phase of a reference clock with the tachometer pulse coming back from one Hall phase of a motor. Both inputs are asynchronous. Each is resynchronised to the system clock and turned into a single-cycle edge strobe. The comparison uses the falling edge of the reference and the rising edge of the feedback. When the reference edge comes first, the block raises a speed-up pulse. When the feedback edge comes first, it raises a slow-down pulse. In both cases the pulse lasts exactly as many clock cycles as the edges are apart. In regulation the loop settles so that one feedback pulse arrives per reference period.

The block also qualifies lock. While a pulse is active, its running width is compared with a dead-zone window given in clock cycles. A pulse that grows past the window counts as a violation. The lock indication only asserts after seven consecutive ticks of a slow time base pass with no violation, so the brief unlock dips seen while the loop hunts during pull-in never reach the output. The lock state also drives a gain-select output, which tells the downstream analog loop to halve its gain while locked. The lock output is active-low, in the manner of an open-drain pin.

Top module: `edge_phase_lock`

## Requirements
- R1: During reset and after its release, with no input edges, `up` and `dn` are 0, `gain_half` is 0 and `lock_n` is 1.
- R2: A falling edge on `ref_clk` with no pending comparison starts an `up` pulse. The pulse ends on the next rising edge of `fb_pulse`. If the two input edges are d clock cycles apart, `up` is high for exactly d cycles. It rises on the third rising clock edge after the input change.
- R3: A rising edge on `fb_pulse` with no pending comparison starts a `dn` pulse. The pulse ends on the next falling edge of `ref_clk`, and `dn` is high for exactly as many cycles as the two edges are apart.
- R4: A reference falling edge and a feedback rising edge in the same cycle produce no pulse. Rising edges of `ref_clk` and falling edges of `fb_pulse` produce no pulse.
- R5: `up` and `dn` are never high in the same cycle.
- R6: `lock_n` goes low on the seventh `tick` after the most recent violation, provided no violation occurs in between. It stays high through the sixth such tick.
- R7: A violation occurs when an `up` or `dn` pulse lasts more than `dz_win` cycles. A violation sets `lock_n` high on the next cycle and restarts the tick count from zero.
- R8: A pulse whose width is at most `dz_win` cycles, including exactly `dz_win`, leaves both the lock state and the tick count unchanged.
- R9: `gain_half` is 1 exactly while locked (`lock_n` low) and 0 otherwise.
- R10: While `en` is 0, `up` and `dn` are 0 and `lock_n` is 1 from the next cycle on, and input edges start no pulse. After `en` returns to 1, the lock must qualify again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enable; 0 holds pulses off and clears lock |
| ref_clk | input | 1 | Asynchronous reference clock |
| fb_pulse | input | 1 | Asynchronous feedback pulse from one Hall phase |
| tick | input | 1 | One-cycle strobe of the slow qualification time base |
| dz_win | input | CNT_W | Dead-zone window in clock cycles |
| up | output | 1 | Speed-up pulse, width equal to phase error |
| dn | output | 1 | Slow-down pulse, width equal to phase error |
| gain_half | output | 1 | 1 selects the halved locked-state loop gain |
| lock_n | output | 1 | Active-low lock indication |

## Verification
The hardest situation to reach is a violation that lands after a partial run of ticks. If the design failed to restart the count, the ticks before the violation and the ticks after it would add up to a false lock. The stimulus first builds four clean ticks, then applies a pulse one cycle wider than the window. It then delivers six more ticks and expects the lock to stay off, and only the seventh tick may bring it on. Pulses exactly at the window width are also applied while locked, to pin down the boundary of the comparison.

// File: rtl/epl_pkg.sv
package epl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,  // reference edge seen first, feedback awaited
    PH_LAG  = 2'd2   // feedback edge seen first, reference awaited
  } ph_state_e;
endpackage

// File: rtl/epl_edge_sync.sv
module epl_edge_sync #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end else begin : g_fall
      assign edge_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/epl_phase_cmp.sv
module epl_phase_cmp
  import epl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ref_fall_i,
  input  logic             fb_rise_i,
  input  logic [CNT_W-1:0] dz_win_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             viol_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ph_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PH_IDLE: begin
          cnt_d = '0;
          if (ref_fall_i && !fb_rise_i) begin
            state_d = PH_LEAD;
            cnt_d   = CNT_ONE;
          end else if (fb_rise_i && !ref_fall_i) begin
            state_d = PH_LAG;
            cnt_d   = CNT_ONE;
          end
        end
        PH_LEAD: begin
          if (fb_rise_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
          end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        PH_LAG: begin
          if (ref_fall_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
          end else if (cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign up_o   = (state_q == PH_LEAD);
  assign dn_o   = (state_q == PH_LAG);
  assign viol_o = (state_q != PH_IDLE) && (cnt_q > dz_win_i);

  assert_up_dn_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o));
  assert_up_needs_ref_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_o) |-> $past(ref_fall_i));
  assert_dn_needs_fb_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_o) |-> $past(fb_rise_i));
  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(up_o || dn_o));
endmodule

// File: rtl/epl_lock_qual.sv
module epl_lock_qual #(
  parameter int LOCK_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic viol_i,
  output logic locked_o
);
  localparam int            QW     = $clog2(LOCK_TICKS + 1);
  localparam logic [QW-1:0] Q_FULL = QW'(LOCK_TICKS);
  localparam logic [QW-1:0] Q_ONE  = QW'(1);

  logic [QW-1:0] qual_q, qual_d;

  always_comb begin
    qual_d = qual_q;
    if (!en_i || viol_i)                 qual_d = '0;
    else if (tick_i && qual_q != Q_FULL) qual_d = qual_q + Q_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_q <= '0;
    else        qual_q <= qual_d;
  end

  assign locked_o = (qual_q == Q_FULL);

  assert_viol_drops_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_i |=> !locked_o);
  assert_lock_rises_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(tick_i));
  assert_disable_clears_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !locked_o);
endmodule

// File: rtl/edge_phase_lock.sv
module edge_phase_lock #(
  parameter int CNT_W      = 8,
  parameter int SYNC_STG   = 2,
  parameter int LOCK_TICKS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ref_clk,
  input  logic             fb_pulse,
  input  logic             tick,
  input  logic [CNT_W-1:0] dz_win,
  output logic             up,
  output logic             dn,
  output logic             gain_half,
  output logic             lock_n
);
  logic [1:0] rst_pipe_q;
  logic       arst_n;
  logic       ref_fall, fb_rise, viol, locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign arst_n = rst_pipe_q[1];

  epl_edge_sync #(.STAGES(SYNC_STG), .RISE(1'b0)) u_ref_sync (
    .clk(clk), .rst_n(arst_n), .d_i(ref_clk), .edge_o(ref_fall));

  epl_edge_sync #(.STAGES(SYNC_STG), .RISE(1'b1)) u_fb_sync (
    .clk(clk), .rst_n(arst_n), .d_i(fb_pulse), .edge_o(fb_rise));

  epl_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(arst_n), .en_i(en), .ref_fall_i(ref_fall),
    .fb_rise_i(fb_rise), .dz_win_i(dz_win), .up_o(up), .dn_o(dn),
    .viol_o(viol));

  epl_lock_qual #(.LOCK_TICKS(LOCK_TICKS)) u_qual (
    .clk(clk), .rst_n(arst_n), .en_i(en), .tick_i(tick),
    .viol_i(viol), .locked_o(locked));

  assign gain_half = locked;
  assign lock_n    = ~locked;
endmodule

// File: tb/sim_edge_phase_lock.sv
`timescale 1ns/1ps
module sim_edge_phase_lock;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n, en, ref_clk, fb_pulse, tick;
  logic [CNT_W-1:0] dz_win;
  logic up, dn, gain_half, lock_n;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;

  edge_phase_lock #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ref_clk(ref_clk), .fb_pulse(fb_pulse),
    .tick(tick), .dz_win(dz_win), .up(up), .dn(dn), .gain_half(gain_half),
    .lock_n(lock_n));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_width(input bit ref_first, input bit is_up, input int d);
    if (d == 0) return 0;
    return (ref_first == is_up) ? d : 0;
  endfunction

  // One comparison: first edge at step 0, second edge d cycles later.
  task automatic run_pair(input bit ref_first, input int d,
                          output int upw, output int dnw, output int both);
    upw = 0; dnw = 0; both = 0;
    for (int i = 0; i <= d + 12; i++) begin
      @(negedge clk);
      if (up) upw++;
      if (dn) dnw++;
      if (up && dn) both++;
      if (i == 0) begin
        if (ref_first || d == 0) ref_clk = 1'b0;
        if (!ref_first || d == 0) fb_pulse = 1'b1;
      end
      if (i == d && d != 0) begin
        if (ref_first) fb_pulse = 1'b1;
        else           ref_clk = 1'b0;
      end
    end
    ref_clk = 1'b1;
    fb_pulse = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (up) upw++;
      if (dn) dnw++;
      if (up && dn) both++;
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    int uw, dw, bw;
    rst_n = 1'b0; en = 1'b1; ref_clk = 1'b1; fb_pulse = 1'b0; tick = 1'b0;
    dz_win = 8'd255;
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) @(negedge clk);
    chk("R1 up in reset", up, 0);
    chk("R1 lock_n in reset", lock_n, 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 dn after reset", dn, 0);
    chk("R1 gain_half after reset", gain_half, 0);
    chk("R1 lock_n after reset", lock_n, 1);

    // R2: exact latency of the up pulse
    @(negedge clk); ref_clk = 1'b0;
    @(negedge clk); chk("R2 up not yet (1)", up, 0);
    @(negedge clk); chk("R2 up not yet (2)", up, 0);
    @(negedge clk); chk("R2 up after third edge", up, 1);
    fb_pulse = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 up ended", up, 0);
    ref_clk = 1'b1; fb_pulse = 1'b0;
    repeat (6) @(negedge clk);

    // R2/R3/R4/R5: constrained random widths and directions
    for (int k = 0; k < 24; k++) begin
      bit rf;
      int d;
      rf = 1'($urandom_range(0, 1));
      d  = (k < 2) ? 0 : int'($urandom_range(1, 24));
      run_pair(rf, d, uw, dw, bw);
      chk(rf ? "R2 up width" : "R3 up width (R4 if d=0)", uw, exp_width(rf, 1'b1, d));
      chk(rf ? "R2 dn width" : "R3 dn width (R4 if d=0)", dw, exp_width(rf, 1'b0, d));
      chk("R5 overlap cycles", bw, 0);
    end

    // Lock qualification, window 8
    dz_win = 8'd8;
    for (int k = 1; k <= 7; k++) begin
      run_pair(1'b1, 2, uw, dw, bw);
      pulse_tick();
      @(negedge clk);
      if (k == 6) chk("R6 not locked after six ticks", lock_n, 1);
      if (k == 7) begin
        chk("R6 locked on seventh tick", lock_n, 0);
        chk("R9 gain_half while locked", gain_half, 1);
      end
    end
    run_pair(1'b0, 8, uw, dw, bw);
    chk("R8 width equal to window keeps lock", lock_n, 0);
    run_pair(1'b1, 8, uw, dw, bw);
    chk("R8 up width equal to window keeps lock", lock_n, 0);
    run_pair(1'b1, 9, uw, dw, bw);
    chk("R7 wide pulse drops lock", lock_n, 1);
    chk("R9 gain_half after unlock", gain_half, 0);

    // Restart of the count by a violation after a partial run
    for (int k = 0; k < 4; k++) pulse_tick();
    run_pair(1'b0, 9, uw, dw, bw);
    for (int k = 0; k < 6; k++) pulse_tick();
    @(negedge clk);
    chk("R7 count restarted after violation", lock_n, 1);
    pulse_tick();
    @(negedge clk);
    chk("R6 locked after seven fresh ticks", lock_n, 0);
    for (int k = 0; k < 3; k++) pulse_tick();
    @(negedge clk);
    chk("R8 extra ticks keep lock", lock_n, 0);

    // Disable
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R10 disable clears lock", lock_n, 1);
    chk("R10 disable clears gain_half", gain_half, 0);
    run_pair(1'b1, 5, uw, dw, bw);
    chk("R10 no up while disabled", uw, 0);
    run_pair(1'b0, 5, uw, dw, bw);
    chk("R10 no dn while disabled", dw, 0);
    en = 1'b1;
    pulse_tick();
    @(negedge clk);
    chk("R10 lock requalifies from zero", lock_n, 1);
    run_pair(1'b0, 6, uw, dw, bw);
    chk("R3 dn width after re-enable", dw, 6);

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule